// File: doc/BRIEF.md
# Core Idle-Mode Sequencer

This block steps one processor core between normal execution and two idle states. In the light idle state (nap), only the execution-unit clocks are gated. The core clock keeps running, so the caches and translation buffers stay coherent and the core can resume in a single cycle. A per-core enable can also ask for a lower clock frequency while the core naps.

The deep idle state (sleep) has a longer entry sequence:

1. The caches are flushed through a request/done handshake.
2. Every core clock is gated.
3. After a short settle time, the supply is requested down to a state-retention level below the operating minimum.

Waking from sleep runs the same steps in reverse. The sequencer restores the voltage first, then the core clock, and then the execution clocks. Configuration state survives sleep, so the core needs no re-initialization.

Each voltage step waits for an acknowledge from the regulator. A wake request that arrives during the cache flush cancels the sleep entry, and the supply is never touched. The regulator, the clock generators and the cache logic sit outside the block and act only as handshake partners.

Top module: `core_idle_seq`

## Requirements
- R1: In reset and right after it, the block is in run mode. Outputs are `exec_clk_en`=1, `core_clk_en`=1, `freq_low_req`=0, `purge_req`=0, `vret_req`=0 and `mode`=0.
- R2: A nap request is taken only in run mode. On the following cycle, `exec_clk_en`=0, `core_clk_en`=1 and `mode`=1. In run mode a sleep request wins over a nap request raised in the same cycle.
- R3: `freq_low_req` equals `slow_en` while the core naps and is 0 in every other state.
- R4: A wake request while napping returns the core to run mode on the next cycle. It wins over a sleep request raised in the same cycle.
- R5: A sleep request from run or nap mode starts the flush. On the next cycle `purge_req`=1, `core_clk_en`=1, `exec_clk_en`=0 and `mode`=3.
- R6: `purge_done` without a wake request ends the flush. It drops `core_clk_en` for exactly `SETTLE` cycles before `vret_req` rises.
- R7: `vret_req` stays high until `vreg_ack` is seen. The block then enters sleep with `mode`=2 and all clocks off.
- R8: A wake request during the flush returns to run mode on the next cycle, even when `purge_done` arrives in the same cycle. `vret_req` never rises on this path.
- R9: A wake request in sleep drops `vret_req` while clocks stay off until `vreg_ack`. `core_clk_en` then returns, with `exec_clk_en` still off, for `SETTLE` cycles, after which run mode resumes.
- R10: `mode` encodes run as 0, nap as 1, sleep as 2, and every intermediate step as 3.
- R11: Wake requests in run mode, nap requests outside run mode, and any request during clock-gate, voltage or sleep steps (other than wake in sleep) have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nap_req | input | 1 | Request light idle |
| sleep_req | input | 1 | Request deep idle |
| wake_req | input | 1 | Request return to run |
| slow_en | input | 1 | Allow frequency reduction while napping |
| purge_done | input | 1 | Cache flush complete |
| vreg_ack | input | 1 | Regulator reached requested level |
| exec_clk_en | output | 1 | Execution-unit clock enable |
| core_clk_en | output | 1 | Whole-core clock enable |
| freq_low_req | output | 1 | Frequency-reduce request |
| purge_req | output | 1 | Cache flush request |
| vret_req | output | 1 | Request retention voltage (0 = operating level) |
| mode | output | 2 | Current mode code |

## Verification
The bench builds the block with `SETTLE` set to 3 instead of the default 2. The gate and ungate windows are then long enough that an off-by-one in the settle counter changes when `vret_req` and `exec_clk_en` switch.

The stimulus holds `vreg_ack` and `purge_done` low for several cycles. This exercises the waits on each handshake and the requests that arrive in the middle of them. Both sleep entry paths are covered, from run and from nap, along with wake-versus-done collisions during the flush.

// File: rtl/core_idle_seq.sv
module core_idle_seq #(
  parameter int unsigned SETTLE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nap_req,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic       slow_en,
  input  logic       purge_done,
  input  logic       vreg_ack,
  output logic       exec_clk_en,
  output logic       core_clk_en,
  output logic       freq_low_req,
  output logic       purge_req,
  output logic       vret_req,
  output logic [1:0] mode
);
  localparam int CW = (SETTLE < 2) ? 1 : $clog2(SETTLE);
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  typedef enum logic [2:0] {
    S_RUN, S_NAP, S_PURGE, S_GATE, S_VDN, S_SLEEP, S_VUP, S_UNGATE
  } st_t;

  st_t st, nx;
  logic [CW-1:0] cnt;
  logic settled;

  assign settled = (cnt == LAST);

  always_comb begin
    nx = st;
    case (st)
      S_RUN:    if (sleep_req) nx = S_PURGE;
                else if (nap_req) nx = S_NAP;
      S_NAP:    if (wake_req) nx = S_RUN;
                else if (sleep_req) nx = S_PURGE;
      S_PURGE:  if (wake_req) nx = S_RUN;
                else if (purge_done) nx = S_GATE;
      S_GATE:   if (settled) nx = S_VDN;
      S_VDN:    if (vreg_ack) nx = S_SLEEP;
      S_SLEEP:  if (wake_req) nx = S_VUP;
      S_VUP:    if (vreg_ack) nx = S_UNGATE;
      S_UNGATE: if (settled) nx = S_RUN;
      default:  nx = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_RUN;
      cnt <= '0;
    end else begin
      st <= nx;
      if ((st == S_GATE || st == S_UNGATE) && !settled) cnt <= cnt + 1'b1;
      else cnt <= '0;
    end
  end

  assign exec_clk_en  = (st == S_RUN);
  assign core_clk_en  = (st == S_RUN) || (st == S_NAP) || (st == S_PURGE) || (st == S_UNGATE);
  assign freq_low_req = (st == S_NAP) && slow_en;
  assign purge_req    = (st == S_PURGE);
  assign vret_req     = (st == S_VDN) || (st == S_SLEEP);
  assign mode = (st == S_RUN)   ? 2'd0 :
                (st == S_NAP)   ? 2'd1 :
                (st == S_SLEEP) ? 2'd2 : 2'd3;

  assert_nap_keeps_core_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (core_clk_en && !exec_clk_en && !vret_req));

  assert_clock_cut_after_purge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en) |-> $past(purge_req && purge_done && !wake_req));

  assert_retention_needs_clocks_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vret_req |-> (!core_clk_en && !exec_clk_en));

  assert_abort_no_voltage_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (purge_req && wake_req) |=> (mode == 2'd0 && !vret_req));

  assert_voltage_up_on_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vret_req) |-> $past(wake_req && mode == 2'd2));

  assert_clock_back_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> $past(vreg_ack && !vret_req));

  assert_freq_only_in_nap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    freq_low_req |-> (mode == 2'd1));
endmodule

// File: tb/test_core_idle_seq.sv
module test_core_idle_seq;
  localparam int unsigned SETTLE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nap_req = 0, sleep_req = 0, wake_req = 0, slow_en = 0, purge_done = 0, vreg_ack = 0;
  logic exec_clk_en, core_clk_en, freq_low_req, purge_req, vret_req;
  logic [1:0] mode;

  integer vectors = 0;
  integer fails = 0;
  integer cycles = 0;
  string  cur_req = "R1";

  always #10 clk = ~clk;

  core_idle_seq #(.SETTLE(SETTLE)) i_core_idle_seq (
    .clk(clk), .rst_n(rst_n), .nap_req(nap_req), .sleep_req(sleep_req),
    .wake_req(wake_req), .slow_en(slow_en), .purge_done(purge_done),
    .vreg_ack(vreg_ack), .exec_clk_en(exec_clk_en), .core_clk_en(core_clk_en),
    .freq_low_req(freq_low_req), .purge_req(purge_req), .vret_req(vret_req),
    .mode(mode));

  // reference: 0 run, 1 nap, 2 flush, 3 gate, 4 v-down, 5 sleep, 6 v-up, 7 ungate
  integer ph = 0;
  integer wait_n = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 0; wait_n <= 0;
    end else begin
      case (ph)
        0: if (sleep_req) ph <= 2; else if (nap_req) ph <= 1;
        1: if (wake_req) ph <= 0; else if (sleep_req) ph <= 2;
        2: if (wake_req) ph <= 0; else if (purge_done) begin ph <= 3; wait_n <= 0; end
        3: if (wait_n + 1 >= SETTLE) ph <= 4; else wait_n <= wait_n + 1;
        4: if (vreg_ack) ph <= 5;
        5: if (wake_req) ph <= 6;
        6: if (vreg_ack) begin ph <= 7; wait_n <= 0; end
        7: if (wait_n + 1 >= SETTLE) ph <= 0; else wait_n <= wait_n + 1;
        default: ph <= 0;
      endcase
    end
  end

  task automatic compare();
    logic [6:0] exp_v, act_v;
    logic [1:0] exp_m;
    exp_m = (ph == 0) ? 2'd0 : (ph == 1) ? 2'd1 : (ph == 5) ? 2'd2 : 2'd3;
    exp_v = {ph == 0, (ph == 0 || ph == 1 || ph == 2 || ph == 7),
             (ph == 1) && slow_en, ph == 2, (ph == 4 || ph == 5), exp_m};
    act_v = {exec_clk_en, core_clk_en, freq_low_req, purge_req, vret_req, mode};
    vectors = vectors + 1;
    if (act_v !== exp_v) begin
      fails = fails + 1;
      $display("FAIL %s cycle %0d: got exec/core/freq/purge/vret/mode=%b expected %b",
               cur_req, cycles, act_v, exp_v);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      cycles = cycles + 1;
      compare();
    end
  endtask

  task automatic clear_in();
    nap_req = 0; sleep_req = 0; wake_req = 0; purge_done = 0; vreg_ack = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #100000;
    fails = fails + 1;
    $display("FAIL watchdog: got hung run expected completion");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    @(negedge clk); compare();
    @(negedge clk); rst_n = 1'b1;
    tick(2);

    cur_req = "R11";   // wake in run has no effect
    wake_req = 1; tick(2); clear_in();

    cur_req = "R2";    // nap with slow clock
    slow_en = 1; nap_req = 1; tick(1);
    cur_req = "R3"; tick(2);
    cur_req = "R11"; nap_req = 1; tick(1); nap_req = 0;
    cur_req = "R4"; wake_req = 1; tick(1); clear_in(); tick(1);

    cur_req = "R3";    // nap without slow clock, wake beats sleep
    slow_en = 0; nap_req = 1; tick(1); nap_req = 0; tick(1);
    cur_req = "R4"; wake_req = 1; sleep_req = 1; tick(1); clear_in(); tick(1);

    cur_req = "R2";    // sleep beats nap in run
    nap_req = 1; sleep_req = 1; tick(1); clear_in();
    cur_req = "R5"; tick(3);
    cur_req = "R8"; wake_req = 1; tick(1); clear_in(); tick(2);

    cur_req = "R5";    // full sleep from nap
    slow_en = 1; nap_req = 1; tick(1); clear_in();
    sleep_req = 1; tick(1); sleep_req = 0; tick(2);
    cur_req = "R6"; purge_done = 1; tick(1); purge_done = 0;
    cur_req = "R11"; wake_req = 1; tick(1); wake_req = 0;
    cur_req = "R6"; tick(SETTLE);
    cur_req = "R7"; tick(3); vreg_ack = 1; tick(1); vreg_ack = 0;
    cur_req = "R10"; tick(2);
    cur_req = "R11"; nap_req = 1; sleep_req = 1; vreg_ack = 1; tick(2); clear_in();
    cur_req = "R9"; wake_req = 1; tick(1); wake_req = 0; tick(2);
    vreg_ack = 1; tick(1); vreg_ack = 0; tick(SETTLE + 2);

    cur_req = "R8";    // done and wake collide
    sleep_req = 1; tick(1); sleep_req = 0; tick(1);
    purge_done = 1; wake_req = 1; tick(1); clear_in(); tick(2);

    cur_req = "R7";    // sleep directly from run with immediate acks
    sleep_req = 1; purge_done = 1; vreg_ack = 1; tick(1); sleep_req = 0;
    tick(SETTLE + 2); vreg_ack = 0;
    cur_req = "R9"; wake_req = 1; tick(1); wake_req = 0; vreg_ack = 1; tick(1);
    clear_in(); tick(SETTLE + 2);

    finish_run();
  end
endmodule